// File: doc/BRIEF.md
# Parallel Configuration Byte Port

This block is the device side of a byte-wide configuration port. An external host supplies the configuration clock and an 8-bit data bus, and it frames each transfer with an active-low chip select and a direction strobe. With the strobe low, bytes go into a small internal FIFO that an internal consumer drains through a valid/ready handshake. When the FIFO cannot take another byte, the port raises a busy flag. The host then keeps the byte steady until busy falls.

Each captured byte is also kept in a small readback store at the next sequential address. With the strobe high, the port reads bytes back from that store in address order and turns on its data output enable. This is the fast path for configuration, as opposed to a one-bit serial load. Whenever the strobe changes direction while selected, the port leaves one clock as a bus turnaround gap, so the host and the port never drive the bus together.

Top module: `cfgp_port`

## Requirements
- R1: A byte on `data_i` is captured at a rising `clk_i` edge only when `cs_ni` is 0, `rdwr_ni` is 0 (write), `busy_o` is 0 and the edge is not a turnaround edge.
- R2: `busy_o` is 1 exactly when the FIFO holds FIFO_DEPTH (default 4) bytes. It returns to 0 after the edge at which one byte drains.
- R3: A byte held on the bus while `busy_o` is 1 is not captured during busy. It is captured exactly once, at the first edge after busy falls.
- R4: The consumer receives captured bytes on `sink_data_o` in capture order. A byte leaves at an edge where `sink_valid_o` and `sink_ready_i` are both 1.
- R5: `data_oe_o` is registered. It is 1 after an edge only if that edge had `cs_ni` = 0 and `rdwr_ni` = 1 (read) and was not a turnaround edge.
- R6: The first selected edge after the direction changes is a turnaround edge. At that edge nothing is captured, no byte is read, and `data_oe_o` stays 0. The direction is remembered across deselected cycles.
- R7: Each non-turnaround selected read edge places the store byte at the read address on `data_o` and advances that address. The read address starts at 0 after reset. Bytes come back in capture order, and both addresses wrap after STORE_DEPTH (default 16) entries.
- R8: With `cs_ni` = 1, nothing is captured and neither the write address nor the read address moves. A transfer interrupted by deselect resumes at the next address.
- R9: After reset, `busy_o`, `data_oe_o` and `sink_valid_o` are 0 and `data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock from the host |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rdwr_ni | input | 1 | Direction: 0 write, 1 readback |
| data_i | input | 8 | Byte from the host |
| data_o | output | 8 | Readback byte |
| data_oe_o | output | 1 | Output enable for the data bus |
| busy_o | output | 1 | FIFO full, host must hold its byte |
| sink_valid_o | output | 1 | FIFO has a byte for the consumer |
| sink_data_o | output | 8 | Oldest byte in the FIFO |
| sink_ready_i | input | 1 | Consumer takes the byte |

## Verification
The hardest situation to reach is a byte held on the bus through several busy cycles, released by exactly one drain, and then captured exactly once. The stimulus gets there by keeping `sink_ready_i` low until four writes fill the FIFO and then pulsing it for a single cycle. The scoreboard catches both a lost byte and a duplicate. A wrap of the readback store is reached by writing more bytes than it holds and then reading across the wrap point.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  typedef enum logic {DIR_WR = 1'b0, DIR_RD = 1'b1} dir_e;
endpackage

// File: rtl/cfgp_dir.sv
module cfgp_dir
  import cfgp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic rdwr_ni,
  output logic wr_en_o,
  output logic rd_en_o,
  output logic oe_o
);
  dir_e dir_q, dir_d;
  logic turn;
  logic oe_q;

  assign dir_d   = rdwr_ni ? DIR_RD : DIR_WR;
  assign turn    = !cs_ni && (dir_d != dir_q);
  assign wr_en_o = !cs_ni && (dir_d == DIR_WR) && !turn;
  assign rd_en_o = !cs_ni && (dir_d == DIR_RD) && !turn;
  assign oe_o    = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= DIR_WR;
      oe_q  <= 1'b0;
    end else begin
      if (!cs_ni) dir_q <= dir_d;  // direction held while deselected
      oe_q <= rd_en_o;
    end
  end

  p_turn_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    turn |=> !oe_q);
  p_oe_needs_cs_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |-> $past(!cs_ni && rdwr_ni));
endmodule

// File: rtl/cfgp_fifo.sv
module cfgp_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         full_o,
  output logic         valid_o,
  output logic [W-1:0] data_o,
  input  logic         ready_i
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          pop;

  assign full_o  = (cnt_q == FULL);
  assign valid_o = (cnt_q != '0);
  assign data_o  = mem[rptr_q];
  assign pop     = valid_o && ready_i;

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + PW'(1);
      if (pop)    rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + PW'(1);
      case ({push_i, pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  p_busy_release_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && ready_i) |=> !full_o);
endmodule

// File: rtl/cfgp_store.sv
module cfgp_store #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         re_i,
  output logic [W-1:0] rdata_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] waddr_q, raddr_q;
  logic [W-1:0]  rdata_q;

  assign rdata_o = rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      waddr_q <= '0;
      raddr_q <= '0;
      rdata_q <= '0;
    end else begin
      if (we_i) waddr_q <= (waddr_q == LAST) ? '0 : waddr_q + AW'(1);
      if (re_i) begin
        rdata_q <= mem[raddr_q];
        raddr_q <= (raddr_q == LAST) ? '0 : raddr_q + AW'(1);
      end
    end
  end

  p_addr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !re_i) |=> ($stable(waddr_q) && $stable(raddr_q)));
  p_one_dir_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && re_i));
endmodule

// File: rtl/cfgp_port.sv
module cfgp_port #(
  parameter int DATA_W      = 8,
  parameter int FIFO_DEPTH  = 4,
  parameter int STORE_DEPTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rdwr_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              busy_o,
  output logic              sink_valid_o,
  output logic [DATA_W-1:0] sink_data_o,
  input  logic              sink_ready_i
);
  logic wr_en, rd_en, full, push;

  cfgp_dir u_dir (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_ni   (cs_ni),
    .rdwr_ni (rdwr_ni),
    .wr_en_o (wr_en),
    .rd_en_o (rd_en),
    .oe_o    (data_oe_o)
  );

  assign busy_o = full;
  assign push   = wr_en && !full;

  cfgp_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .data_i  (data_i),
    .full_o  (full),
    .valid_o (sink_valid_o),
    .data_o  (sink_data_o),
    .ready_i (sink_ready_i)
  );

  cfgp_store #(.W(DATA_W), .DEPTH(STORE_DEPTH)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (push),
    .wdata_i (data_i),
    .re_i    (rd_en),
    .rdata_o (data_o)
  );

  p_capture_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push |-> (!cs_ni && !rdwr_ni));
  p_busy_blocks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !sink_ready_i) |=> busy_o);
endmodule

// File: tb/cfgp_port_tb.sv
module cfgp_port_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1, rdwr_ni = 1'b0, sink_ready_i = 1'b0;
  logic [7:0] data_i = '0;
  logic [7:0] data_o, sink_data_o;
  logic data_oe_o, busy_o, sink_valid_o;

  int checks = 0, fails = 0, pops = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  logic [7:0] mdl[16];
  int mw = 0;

  always #2.5 clk = ~clk;

  cfgp_port u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .rdwr_ni(rdwr_ni),
    .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o), .busy_o(busy_o),
    .sink_valid_o(sink_valid_o), .sink_data_o(sink_data_o), .sink_ready_i(sink_ready_i)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic expect_cap(input logic [7:0] b);
    exp_q.push_back(b);
    mdl[mw] = b;
    mw = (mw + 1) % 16;
  endtask

  // monitor: compares every byte handed to the consumer (R4)
  always begin
    @(negedge clk);
    #2;
    if (rst_ni && sink_valid_o && sink_ready_i) begin
      pops++;
      if (exp_q.size() == 0) chk("R1 unexpected capture", sink_data_o, 8'hxx);
      else chk("R4 sink order", sink_data_o, exp_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R9 busy", {7'b0, busy_o}, 8'h00);
    chk("R9 oe", {7'b0, data_oe_o}, 8'h00);
    chk("R9 sink_valid", {7'b0, sink_valid_o}, 8'h00);
    chk("R9 data_o", data_o, 8'h00);

    // fill FIFO with consumer stalled
    cs_ni = 1'b0; rdwr_ni = 1'b0;
    for (int i = 0; i < 4; i++) begin
      data_i = 8'hA0 + 8'(i);
      expect_cap(data_i);
      @(negedge clk);
    end
    chk("R2 busy when full", {7'b0, busy_o}, 8'h01);
    chk("R4 head byte", sink_data_o, 8'hA0);
    data_i = 8'hA4;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk("R3 busy holds", {7'b0, busy_o}, 8'h01);
    end
    sink_ready_i = 1'b1;
    @(negedge clk);
    chk("R2 busy release", {7'b0, busy_o}, 8'h00);
    sink_ready_i = 1'b0;
    expect_cap(8'hA4);
    @(negedge clk);
    chk("R3 held byte captured", {7'b0, busy_o}, 8'h01);
    cs_ni = 1'b1; sink_ready_i = 1'b1;
    repeat (6) @(negedge clk);
    chk("R4 drained", {7'b0, sink_valid_o}, 8'h00);
    chk("R3 once", 8'(pops), 8'd5);

    // deselected cycles with changing data
    for (int i = 0; i < 3; i++) begin
      data_i = 8'hE0 + 8'(i);
      @(negedge clk);
      chk("R8 no capture deselected", {7'b0, sink_valid_o}, 8'h00);
    end

    // interrupted write burst
    cs_ni = 1'b0;
    data_i = 8'hB0; expect_cap(data_i); @(negedge clk);
    data_i = 8'hB1; expect_cap(data_i); @(negedge clk);
    cs_ni = 1'b1; data_i = 8'h5A; @(negedge clk);
    cs_ni = 1'b0; data_i = 8'hB2; expect_cap(data_i); @(negedge clk);
    cs_ni = 1'b1;
    repeat (3) @(negedge clk);

    // readback
    cs_ni = 1'b0; rdwr_ni = 1'b1;
    @(negedge clk);
    chk("R6 read turnaround oe", {7'b0, data_oe_o}, 8'h00);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R5 oe in read", {7'b0, data_oe_o}, 8'h01);
      chk("R7 readback", data_o, mdl[k]);
    end
    cs_ni = 1'b1;
    @(negedge clk);
    chk("R5 oe off deselected", {7'b0, data_oe_o}, 8'h00);
    cs_ni = 1'b0;
    for (int k = 4; k < 8; k++) begin
      @(negedge clk);
      chk("R8 read resumes", data_o, mdl[k]);
    end

    // back to write: turnaround edge must not capture
    rdwr_ni = 1'b0; data_i = 8'hC0;
    @(negedge clk);
    chk("R5 oe off on write", {7'b0, data_oe_o}, 8'h00);
    chk("R6 write turnaround", {7'b0, sink_valid_o}, 8'h00);
    for (int j = 0; j < 9; j++) begin
      data_i = 8'hC0 + 8'(j);
      expect_cap(data_i);
      @(negedge clk);
    end
    cs_ni = 1'b1;
    repeat (3) @(negedge clk);

    cs_ni = 1'b0; rdwr_ni = 1'b1;
    @(negedge clk);
    chk("R6 turnaround again", {7'b0, data_oe_o}, 8'h00);
    for (int k = 8; k < 17; k++) begin
      @(negedge clk);
      chk("R7 readback wrap", data_o, mdl[k % 16]);
    end
    cs_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 all delivered", 8'(exp_q.size()), 8'd0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule